// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block is the sequencing half of a microprogrammed control unit. A micro-PC register addresses an internal control store. Each stored word carries sixteen control bits, which leave the block unchanged as the control outputs for the cycle in which that word is addressed. Each word also carries sequencing fields: a 3-bit condition selector, an end marker, a dispatch marker and an 8-bit branch target. The datapath that consumes the control bits is outside the block.

On every clock edge a next-address selector picks the following micro-PC value. An end word returns control to the shared fetch routine at address 0. A dispatch word, which marks the step where a new instruction lands in the instruction register, jumps to the routine start that is looked up from the 4-bit opcode. A conditional word jumps to its target when the selected flag is set. Otherwise the micro-PC counts up by one. The store is filled at elaboration from an arithmetic rule, so the whole sequencing behaviour can be predicted from the requirements below.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst_n` is low, and right after it goes low (asynchronously), `uaddr` is 0 and `ctrl` is 16'h0001. The first clock edge after release moves to address 1.
- R2: `ctrl` is the control field of the word at the current `uaddr`, in the same cycle. The store contents are as follows. Word 0 has ctrl 16'h0001 and no sequencing marks. Word 1 has ctrl 16'h0002, dispatch set, condition 1 and target 250. For a routine address a in 16..143, with op=(a-16)/8 and k=(a-16)%8, ctrl is op*4096 + k*256 + a. Every other address has ctrl 0 and end set.
- R3: A word with no end mark, no dispatch mark and an unmet (or absent) condition makes the next `uaddr` equal to the current one plus 1.
- R4: A word with the end mark makes the next `uaddr` 0, whatever its dispatch mark and condition are. In a routine, k=7 sets end with condition 1 and target 200. For op 15, k=3 sets both end and dispatch.
- R5: A dispatch word without an end mark makes the next `uaddr` equal to 16 + 8*`ir_opcode`, even when its own condition holds.
- R6: The condition selector values are 0 never, 1 always, 2 `flags[0]` (negative), 3 `flags[1]` (zero), 4 `flags[2]` (carry) and 5 `flags[3]` (overflow). Values 6 and 7 never branch. A routine word with k=2 has condition op%8 and target a+4. When the condition holds, and neither end nor dispatch is set, the next `uaddr` is the target.
- R7: `ir_opcode` affects the sequence only on a dispatch word. `flags` affect it only on a word whose condition is 2..5.
- R8: Every instruction passes through the shared fetch words at 0 and 1 before its routine runs, and returns to 0 when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| flags | input | 4 | Status flags: bit0 negative, bit1 zero, bit2 carry, bit3 overflow |
| ctrl | output | 16 | Control signals of the current microword |
| uaddr | output | 8 | Current micro-PC |

## Verification
A corrupted micro-PC shows up at both outputs in the very next cycle. `uaddr` leaves the expected path, and `ctrl`, which encodes the opcode, the step and the address, no longer matches the predicted word. Because a wrong address leads to wrong sequencing fields, one bad step then derails the rest of the instruction's path until an end word returns it to 0. The sweep runs every opcode against every flag pattern, so each condition selector is exercised both taken and not taken. Noise is placed on inputs that should be ignored, so a wrongly sampled input changes the path within one cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int FLAG_W = 4;
   localparam int FLG_NEG   = 0;
   localparam int FLG_ZERO  = 1;
   localparam int FLG_CARRY = 2;
   localparam int FLG_OVF   = 3;

   typedef enum logic [2:0] {
      CND_NEVER  = 3'd0,
      CND_ALWAYS = 3'd1,
      CND_NEG    = 3'd2,
      CND_ZERO   = 3'd3,
      CND_CARRY  = 3'd4,
      CND_OVF    = 3'd5
   } cond_e;

   function automatic logic cond_met(input logic [2:0] sel, input logic [FLAG_W-1:0] fl);
      logic r;
      case (sel)
         CND_ALWAYS: r = 1'b1;
         CND_NEG:    r = fl[FLG_NEG];
         CND_ZERO:   r = fl[FLG_ZERO];
         CND_CARRY:  r = fl[FLG_CARRY];
         CND_OVF:    r = fl[FLG_OVF];
         default:    r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int CTRL_W = 16,
   parameter int ADDR_W = 8,
   parameter int NOPS   = 16,
   parameter int BASE   = 16,
   parameter int LEN    = 8,
   parameter int FETCH  = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CTRL_W-1:0] ctrl,
   output logic [2:0]        cond,
   output logic              is_end,
   output logic              dispatch,
   output logic [ADDR_W-1:0] target
);
   localparam int DEPTH  = 2 ** ADDR_W;
   localparam int RT_TOP = BASE + NOPS * LEN;

   logic [CTRL_W-1:0] ctrl_mem [DEPTH];
   logic [2:0]        cond_mem [DEPTH];
   logic              end_mem  [DEPTH];
   logic              disp_mem [DEPTH];
   logic [ADDR_W-1:0] tgt_mem  [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      if (a == FETCH) begin : g_f0
         assign ctrl_mem[a] = CTRL_W'(1);
         assign cond_mem[a] = 3'd0;
         assign end_mem[a]  = 1'b0;
         assign disp_mem[a] = 1'b0;
         assign tgt_mem[a]  = '0;
      end else if (a == FETCH + 1) begin : g_f1
         assign ctrl_mem[a] = CTRL_W'(2);
         assign cond_mem[a] = 3'd1;
         assign end_mem[a]  = 1'b0;
         assign disp_mem[a] = 1'b1;
         assign tgt_mem[a]  = ADDR_W'(DEPTH - 6);
      end else if (a >= BASE && a < RT_TOP) begin : g_rt
         localparam int OP = (a - BASE) / LEN;
         localparam int K  = (a - BASE) % LEN;
         assign ctrl_mem[a] = CTRL_W'(OP * 4096 + K * 256 + (a % 256));
         if (K == 2) begin : g_br
            assign cond_mem[a] = 3'(OP % 8);
            assign tgt_mem[a]  = ADDR_W'(a + 4);
            assign end_mem[a]  = 1'b0;
            assign disp_mem[a] = 1'b0;
         end else if (K == LEN - 1) begin : g_end
            assign cond_mem[a] = 3'd1;
            assign tgt_mem[a]  = ADDR_W'(DEPTH - 56);
            assign end_mem[a]  = 1'b1;
            assign disp_mem[a] = 1'b0;
         end else if (K == 3 && OP == NOPS - 1) begin : g_both
            assign cond_mem[a] = 3'd0;
            assign tgt_mem[a]  = '0;
            assign end_mem[a]  = 1'b1;
            assign disp_mem[a] = 1'b1;
         end else begin : g_plain
            assign cond_mem[a] = 3'd0;
            assign tgt_mem[a]  = '0;
            assign end_mem[a]  = 1'b0;
            assign disp_mem[a] = 1'b0;
         end
      end else begin : g_unused
         assign ctrl_mem[a] = '0;
         assign cond_mem[a] = 3'd0;
         assign end_mem[a]  = 1'b1;
         assign disp_mem[a] = 1'b0;
         assign tgt_mem[a]  = '0;
      end
   end

   assign ctrl     = ctrl_mem[addr];
   assign cond     = cond_mem[addr];
   assign is_end   = end_mem[addr];
   assign dispatch = disp_mem[addr];
   assign target   = tgt_mem[addr];

endmodule

// File: rtl/useq_opmap.sv
module useq_opmap #(
   parameter int ADDR_W = 8,
   parameter int OP_W   = 4,
   parameter int BASE   = 16,
   parameter int LEN    = 8
) (
   input  logic [OP_W-1:0]   opcode,
   output logic [ADDR_W-1:0] start
);
   localparam int NOPS = 2 ** OP_W;

   logic [ADDR_W-1:0] map [NOPS];

   for (genvar i = 0; i < NOPS; i++) begin : g_map
      assign map[i] = ADDR_W'(BASE + i * LEN);
   end

   assign start = map[opcode];

endmodule

// File: rtl/useq_next.sv
module useq_next #(
   parameter int ADDR_W = 8,
   parameter int FETCH  = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         is_end,
   input  logic                         dispatch,
   input  logic [2:0]                   cond,
   input  logic [useq_pkg::FLAG_W-1:0]  flags,
   input  logic [ADDR_W-1:0]            target,
   input  logic [ADDR_W-1:0]            start,
   output logic [ADDR_W-1:0]            upc
);
   logic              taken;
   logic [ADDR_W-1:0] upc_nxt;

   always_comb begin
      taken = useq_pkg::cond_met(cond, flags);
      if (is_end)        upc_nxt = ADDR_W'(FETCH);
      else if (dispatch) upc_nxt = start;
      else if (taken)    upc_nxt = target;
      else               upc_nxt = upc + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= ADDR_W'(FETCH);
      else        upc <= upc_nxt;
   end

   a_r4_end_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      is_end |=> upc == ADDR_W'(FETCH));

   a_r5_dispatch_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_end && dispatch) |=> upc == $past(start));

   a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_end && !dispatch && taken) |=> upc == $past(target));

   a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_end && !dispatch && !taken) |=> upc == ADDR_W'($past(upc) + 1'b1));

   a_r6_no_branch_on_never: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == 3'd0 || cond > 3'd5) |-> !taken);

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer #(
   parameter int CTRL_W = 16,
   parameter int ADDR_W = 8,
   parameter int OP_W   = 4,
   parameter int BASE   = 16,
   parameter int LEN    = 8,
   parameter int FETCH  = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [OP_W-1:0]             ir_opcode,
   input  logic [useq_pkg::FLAG_W-1:0] flags,
   output logic [CTRL_W-1:0]           ctrl,
   output logic [ADDR_W-1:0]           uaddr
);
   localparam int NOPS  = 2 ** OP_W;
   localparam int DEPTH = 2 ** ADDR_W;

   if (BASE + NOPS * LEN > DEPTH) begin : g_chk_fit
      $error("routines do not fit in the control store");
   end
   if (BASE < FETCH + 2) begin : g_chk_base
      $error("routines overlap the fetch words");
   end
   if (LEN < 8) begin : g_chk_len
      $error("routine slot must hold at least 8 words");
   end
   if (CTRL_W < 16) begin : g_chk_ctrl
      $error("control field narrower than 16 bits");
   end

   logic [2:0]        w_cond;
   logic              w_end;
   logic              w_disp;
   logic [ADDR_W-1:0] w_tgt;
   logic [ADDR_W-1:0] w_start;

   useq_store #(
      .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .NOPS(NOPS),
      .BASE(BASE), .LEN(LEN), .FETCH(FETCH)
   ) u_store (
      .addr(uaddr), .ctrl(ctrl), .cond(w_cond),
      .is_end(w_end), .dispatch(w_disp), .target(w_tgt)
   );

   useq_opmap #(
      .ADDR_W(ADDR_W), .OP_W(OP_W), .BASE(BASE), .LEN(LEN)
   ) u_map (
      .opcode(ir_opcode), .start(w_start)
   );

   useq_next #(
      .ADDR_W(ADDR_W), .FETCH(FETCH)
   ) u_next (
      .clk(clk), .rst_n(rst_n), .is_end(w_end), .dispatch(w_disp),
      .cond(w_cond), .flags(flags), .target(w_tgt), .start(w_start),
      .upc(uaddr)
   );

endmodule

// File: tb/sim_micro_sequencer.sv
`timescale 1ns/1ps
module sim_micro_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ir_opcode = 4'd0;
   logic [3:0]  flags = 4'd0;
   logic [15:0] ctrl;
   logic [7:0]  uaddr;
   int total = 0;
   int bad = 0;
   int exp_pc = 0;

   always #4 clk = ~clk;

   micro_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode),
      .flags(flags), .ctrl(ctrl), .uaddr(uaddr)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // word model from R2, R4, R5, R6
   task automatic word_of(input int a, output int c, output int cnd,
                          output bit e, output bit d, output int t);
      c = 0; cnd = 0; e = 0; d = 0; t = 0;
      if (a == 0) c = 1;
      else if (a == 1) begin c = 2; d = 1; cnd = 1; t = 250; end
      else if (a >= 16 && a < 144) begin
         int op = (a - 16) / 8;
         int k  = (a - 16) % 8;
         c = op * 4096 + k * 256 + a;
         if (k == 2) begin cnd = op % 8; t = a + 4; end
         if (k == 7) begin e = 1; cnd = 1; t = 200; end
         if (op == 15 && k == 3) begin e = 1; d = 1; end
      end else e = 1;
   endtask

   function automatic bit met(input int cnd, input logic [3:0] fl);
      case (cnd)
         1: return 1'b1;
         2: return fl[0];
         3: return fl[1];
         4: return fl[2];
         5: return fl[3];
         default: return 1'b0;
      endcase
   endfunction

   string last_tag = "R1";

   // called just after a falling edge; returns just after the next one
   task automatic step(input int op, input logic [3:0] fl);
      int c, cnd, t, nxt;
      bit e, d;
      word_of(exp_pc, c, cnd, e, d, t);
      check(last_tag, uaddr, exp_pc);
      check((exp_pc < 2) ? "R2 R8" : "R2", ctrl, c);
      ir_opcode = d ? 4'(op) : ~4'(op);
      flags = (cnd >= 2 && cnd <= 5) ? fl : ~fl;
      if (e) begin nxt = 0; last_tag = "R4 R8"; end
      else if (d) begin nxt = 16 + 8 * op; last_tag = "R5 R7"; end
      else if (met(cnd, flags)) begin nxt = t; last_tag = "R6 R7"; end
      else begin nxt = (exp_pc + 1) % 256; last_tag = (cnd >= 2) ? "R6 R7" : "R3"; end
      @(posedge clk);
      @(negedge clk);
      exp_pc = nxt;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", uaddr, 0);
      check("R1", ctrl, 16'h0001);
      rst_n = 1'b1;
      exp_pc = 0;
      for (int op = 0; op < 16; op++) begin
         for (int fl = 0; fl < 16; fl++) begin
            do step(op, 4'(fl)); while (exp_pc != 0);
         end
      end
      // asynchronous reset in the middle of a routine (R1)
      repeat (4) step(5, 4'hF);
      rst_n = 1'b0;
      #1;
      check("R1", uaddr, 0);
      check("R1", ctrl, 16'h0001);
      @(negedge clk);
      check("R1", uaddr, 0);
      rst_n = 1'b1;
      exp_pc = 0;
      last_tag = "R1";
      step(2, 4'h0);
      check("R1", uaddr, 1);
      finish_run();
   end

endmodule